// File: doc/BRIEF.md
# Presettable Cascadable Up-Counter Stage

This block is one stage of a synchronous binary up-counter with a parallel preset, a clear and a carry output. On each rising clock edge the stage does one of four things: it clears to zero, takes a data word, steps up by one, or keeps its value. Which one it does depends on the active-low clear, the active-low load and two count enables. Both enables must be high for the stage to count. The second enable, T, also gates the carry output. The carry is high while T is high and the stage sits at its all-ones value.

Wider counters are made from identical stages on a common clock. Each stage's carry drives the T enable of the next stage, and no extra gating is needed. A build-time parameter selects how the clear behaves. In one setting it acts at once, without the clock. In the other it takes effect at the next edge, which lets a decode of a terminal count shorten the count length.

Top module: `cnt_stage`

## Requirements
- R1: The count changes only on a rising clock edge. A change on load, data or the enables between edges leaves the count unchanged until the next edge.
- R2: With clear high and load low, the count takes the data word at the next edge, whatever the enable levels.
- R3: With ASYNC_CLR=1, clear low forces the count to 0 at once, without waiting for an edge. The count stays 0 across edges while clear is low, even with load low.
- R4: With ASYNC_CLR=0, clear low sets the count to 0 at the next edge and not before. When clear and load are both low on the same edge, clear wins.
- R5: With clear and load both high, the count increments when enable P and enable T are both 1. When either enable is 0 the count holds.
- R6: The carry output is 1 exactly when enable T is 1 and the count is all ones (15 for the default width). Enable P has no effect on the carry.
- R7: An increment from all ones gives 0.
- R8: Three stages chained carry to T, with a common enable on the first stage's P and T, count as one 12-bit synchronous counter. This includes the ripple across 0x0FF to 0x100 and the wrap from 0xFFF to 0x000.
- R9: With ASYNC_CLR=0, driving clear from a decode of count 9 gives a repeating 0 to 9 sequence.
- R10: The sequence clear, load 12, then counting gives 0, 12, 13, 14, 15, 0, 1, 2. Dropping either enable then holds the count at 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous according to ASYNC_CLR |
| ld_n | input | 1 | Active-low parallel load |
| en_p | input | 1 | Count enable that does not affect the carry |
| en_t | input | 1 | Count enable that also gates the carry |
| d | input | WIDTH | Preset data word |
| q | output | WIDTH | Current count |
| rco | output | 1 | Ripple carry: en_t high and count all ones |

## Verification
The bench aims at the priority between controls on the same edge. It checks that clear beats load, and that load wins with both enables low or both high. A design with the wrong order would load 7 or keep counting where 0 or the data word is expected. It holds the count at 15 with P low, which separates the two enables. A carry gated by P, or a carry that ignores T, shows up there. The bench also checks the wrap from 15 and the carry ripple through three chained stages, where a late or missing carry would stall the upper digits. It checks the timing of each clear mode: an immediate clear that waits for the clock, or a clocked clear that acts at once, gives a count that differs before the edge. It also breaks the divide-by-ten loop.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } cnt_op_e;

    // Control lines after inversion to active-high
    typedef struct packed {
        logic clr;
        logic ld;
        logic p;
        logic t;
    } cnt_ctl_s;

    // Fixed priority: clear, load, count, hold
    function automatic cnt_op_e pick_op(cnt_ctl_s c);
        if (c.clr)             return OP_CLEAR;
        else if (c.ld)         return OP_LOAD;
        else if (c.p && c.t)   return OP_COUNT;
        else                   return OP_HOLD;
    endfunction

endpackage

// File: rtl/cnt_decode.sv
module cnt_decode
    import cnt_pkg::*;
(
    input  logic    clr_n,
    input  logic    ld_n,
    input  logic    en_p,
    input  logic    en_t,
    output cnt_op_e op
);
    cnt_ctl_s ctl;

    always_comb begin
        ctl.clr = ~clr_n;
        ctl.ld  = ~ld_n;
        ctl.p   = en_p;
        ctl.t   = en_t;
        op      = pick_op(ctl);
    end
endmodule

// File: rtl/cnt_state.sv
module cnt_state
    import cnt_pkg::*;
#(
    parameter int WIDTH     = 4,
    parameter bit ASYNC_CLR = 1'b0
) (
    input  logic             clk,
    input  logic             clr_n,
    input  cnt_op_e          op,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] nxt;

    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = d;
            OP_COUNT: nxt = q + ONE;
            default:  nxt = q;
        endcase
    end

    generate
        if (ASYNC_CLR) begin : g_async
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) q <= '0;
                else        q <= nxt;
            end
        end else begin : g_sync
            always_ff @(posedge clk) begin
                q <= nxt;
            end
        end
    endgenerate
endmodule

// File: rtl/cnt_tc.sv
module cnt_tc #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] q,
    input  logic             en_t,
    output logic             rco
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    assign rco = en_t && (q == TOP);
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
    import cnt_pkg::*;
#(
    parameter int WIDTH     = 4,
    parameter bit ASYNC_CLR = 1'b0
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             ld_n,
    input  logic             en_p,
    input  logic             en_t,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    output logic             rco
);
    cnt_op_e op;

    cnt_decode u_dec (
        .clr_n (clr_n),
        .ld_n  (ld_n),
        .en_p  (en_p),
        .en_t  (en_t),
        .op    (op)
    );

    cnt_state #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_st (
        .clk   (clk),
        .clr_n (clr_n),
        .op    (op),
        .d     (d),
        .q     (q)
    );

    cnt_tc #(.WIDTH(WIDTH)) u_tc (
        .q    (q),
        .en_t (en_t),
        .rco  (rco)
    );
endmodule

// File: rtl/cnt_stage_chk.sv
module cnt_stage_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             clr_n,
    input logic             ld_n,
    input logic             en_p,
    input logic             en_t,
    input logic [WIDTH-1:0] d,
    input logic [WIDTH-1:0] q,
    input logic             rco
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    logic armed = 1'b0;
    always_ff @(posedge clk) if (!clr_n) armed <= 1'b1;

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!armed)
        !clr_n |=> q == '0); // R4

    AST_LOAD_TAKES_D: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && !ld_n) |=> (!clr_n || q == $past(d))); // R2

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && ld_n && en_p && en_t) |=> (!clr_n || q == WIDTH'($past(q) + 1'b1))); // R5

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && ld_n && !(en_p && en_t)) |=> (!clr_n || q == $past(q))); // R5

    AST_CARRY_NEEDS_T: assert property (@(posedge clk) disable iff (!armed)
        rco |-> (en_t && q == TOP)); // R6

    AST_CARRY_AT_TOP: assert property (@(posedge clk) disable iff (!armed)
        (en_t && q == TOP) |-> rco); // R6
endmodule

bind cnt_stage cnt_stage_chk #(.WIDTH(WIDTH)) u_chk (
    .clk   (clk),
    .clr_n (clr_n),
    .ld_n  (ld_n),
    .en_p  (en_p),
    .en_t  (en_t),
    .d     (d),
    .q     (q),
    .rco   (rco)
);

// File: tb/sim_cnt_stage.sv
`timescale 1ns/1ps
module sim_cnt_stage;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Unit under test, synchronous clear
    logic       clr_n = 1'b1, ld_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
    logic [3:0] d = '0, q;
    logic       rco;

    cnt_stage #(.WIDTH(4), .ASYNC_CLR(1'b0)) u0 (
        .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .en_p(en_p), .en_t(en_t),
        .d(d), .q(q), .rco(rco));

    // Asynchronous-clear variant
    logic       a_clr_n = 1'b0;
    logic [3:0] a_q;
    logic       a_rco;

    cnt_stage #(.WIDTH(4), .ASYNC_CLR(1'b1)) u_async (
        .clk(clk), .clr_n(a_clr_n), .ld_n(ld_n), .en_p(en_p), .en_t(en_t),
        .d(d), .q(a_q), .rco(a_rco));

    // Three-stage cascade
    logic        c_clr_n = 1'b0, c_ld_n = 1'b1, c_en = 1'b0;
    logic [11:0] c_d = '0, c_q;
    logic [2:0]  c_rco;

    for (genvar k = 0; k < 3; k++) begin : g_chain
        logic t_in;
        if (k == 0) begin : g_first
            assign t_in = c_en;
        end else begin : g_next
            assign t_in = c_rco[k-1];
        end
        cnt_stage #(.WIDTH(4), .ASYNC_CLR(1'b0)) u_s (
            .clk(clk), .clr_n(c_clr_n), .ld_n(c_ld_n), .en_p(c_en), .en_t(t_in),
            .d(c_d[4*k +: 4]), .q(c_q[4*k +: 4]), .rco(c_rco[k]));
    end

    // Divide-by-ten loop: clear decoded from count 9
    logic       m_rst_n = 1'b0;
    logic [3:0] m_q;
    logic       m_rco;
    logic       m_clr_n;
    assign m_clr_n = m_rst_n & (m_q != 4'd9);

    cnt_stage #(.WIDTH(4), .ASYNC_CLR(1'b0)) u_mod (
        .clk(clk), .clr_n(m_clr_n), .ld_n(1'b1), .en_p(1'b1), .en_t(1'b1),
        .d(4'd0), .q(m_q), .rco(m_rco));

    // Vector: {clr_n, ld_n, en_p, en_t, d[3:0], exp_q[3:0], exp_rco}
    localparam int NV = 15;
    localparam logic [12:0] VEC [NV] = '{
        {4'b0111, 4'd0,  4'd0,  1'b0},
        {4'b1000, 4'd12, 4'd12, 1'b0},
        {4'b1111, 4'd0,  4'd13, 1'b0},
        {4'b1111, 4'd0,  4'd14, 1'b0},
        {4'b1111, 4'd0,  4'd15, 1'b1},
        {4'b1111, 4'd0,  4'd0,  1'b0},
        {4'b1111, 4'd0,  4'd1,  1'b0},
        {4'b1111, 4'd0,  4'd2,  1'b0},
        {4'b1101, 4'd0,  4'd2,  1'b0},
        {4'b1110, 4'd0,  4'd2,  1'b0},
        {4'b0011, 4'd7,  4'd0,  1'b0},
        {4'b1011, 4'd15, 4'd15, 1'b1},
        {4'b1101, 4'd0,  4'd15, 1'b1},
        {4'b1110, 4'd0,  4'd15, 1'b0},
        {4'b1111, 4'd0,  4'd0,  1'b0}
    };

    task automatic step_check();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        // Table walk: R10 sequence, R2, R4, R5, R6, R7
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {clr_n, ld_n, en_p, en_t} = VEC[i][12:9];
            d = VEC[i][8:5];
            step_check();
            chk($sformatf("R10 R2 R4 R5 R7 table step %0d q", i), 32'(q), 32'(VEC[i][4:1]));
            chk($sformatf("R6 table step %0d rco", i), 32'(rco), 32'(VEC[i][0]));
        end

        // R1: a load set up between edges does nothing until the edge
        @(negedge clk);
        en_p = 1'b0; en_t = 1'b0; ld_n = 1'b0; d = 4'd9;
        #5;
        chk("R1 load before edge", 32'(q), 32'd0);
        step_check();
        chk("R1 load at edge", 32'(q), 32'd9);

        // R4: synchronous clear waits for the edge
        @(negedge clk);
        ld_n = 1'b1; clr_n = 1'b0;
        #3;
        chk("R4 sync clear before edge", 32'(q), 32'd9);
        step_check();
        chk("R4 sync clear at edge", 32'(q), 32'd0);

        // R3: asynchronous clear acts at once
        @(negedge clk);
        clr_n = 1'b1; a_clr_n = 1'b1; ld_n = 1'b0; d = 4'd6;
        step_check();
        chk("R3 async variant load", 32'(a_q), 32'd6);
        #3;
        a_clr_n = 1'b0;
        #1;
        chk("R3 async clear without edge", 32'(a_q), 32'd0);
        step_check();
        chk("R3 async clear held with load low", 32'(a_q), 32'd0);
        @(negedge clk);
        ld_n = 1'b1; a_clr_n = 1'b1;

        // R8: cascade ripple across 0x0FF
        @(negedge clk);
        c_clr_n = 1'b1; c_ld_n = 1'b0; c_d = 12'h0FE;
        step_check();
        chk("R8 cascade load", 32'(c_q), 32'h0FE);
        @(negedge clk);
        c_ld_n = 1'b1; c_en = 1'b1;
        for (int k = 1; k <= 3; k++) begin
            step_check();
            chk("R8 cascade count", 32'(c_q), 32'(12'h0FE + k));
        end
        // R8: wrap at full width
        @(negedge clk);
        c_en = 1'b0; c_ld_n = 1'b0; c_d = 12'hFFE;
        step_check();
        @(negedge clk);
        c_ld_n = 1'b1; c_en = 1'b1;
        step_check();
        chk("R8 cascade at top", 32'(c_q), 32'hFFF);
        chk("R8 cascade top carry", 32'(c_rco[2]), 32'd1);
        step_check();
        chk("R8 cascade wrap", 32'(c_q), 32'h000);
        step_check();
        chk("R8 cascade after wrap", 32'(c_q), 32'h001);

        // R9: divide-by-ten
        @(negedge clk);
        m_rst_n = 1'b0;
        step_check();
        chk("R9 mod start", 32'(m_q), 32'd0);
        @(negedge clk);
        m_rst_n = 1'b1;
        for (int k = 1; k <= 25; k++) begin
            step_check();
            chk($sformatf("R9 mod step %0d", k), 32'(m_q), 32'(k % 10));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule